// File: doc/BRIEF.md
# Program Counter with Link Register

This block keeps the 16-bit instruction address for a CPU whose operand buses are only 8 bits wide. Each instruction passes through an Execute phase and then a Commit phase. An operation code from the decoder is held for both phases, together with the A-bus and B-bus bytes and the byte read from register C. Full 16-bit addresses are built from two bytes: the A bus supplies the high byte and the B bus the low byte.

Beside the program counter the block holds a 16-bit link register. A subroutine call saves the current address in it, and a return resumes two bytes past that address. Software can save the link register to the register file one byte at a time through the C bus, and can reload it whole from the A and B buses. Relative branches take their displacement from a single 8-bit register. Forward branches replace the step. Backward branches subtract the displacement and keep the step. A forward branch of zero therefore halts, and so does a backward branch of two.

Top module: `pc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the PC and the link register are set to 0x0000.
- R2: On a cycle with `commit` low, the PC and the link register keep their values, whatever the operation is.
- R3: On a commit with op STEP (code 0), or with any unassigned code (12 to 15), the PC becomes PC+2, modulo 2^16.
- R4: JUMP (code 1) loads the PC with {A,B}, with A as the high byte. JUMPZERO (code 2) does the same only when `c_val` is zero, and otherwise steps by 2.
- R5: BRANCH (code 3) sets PC = PC + A, zero-extended. BRANCHZERO (code 4) does so only when B is zero, and otherwise steps by 2. A displacement of zero leaves the PC unchanged.
- R6: BRANCHBACK (code 5) sets PC = PC − A + 2. BRANCHBACKZERO (code 6) does so only when B is zero, and otherwise steps by 2. A displacement of two leaves the PC unchanged, and the arithmetic wraps modulo 2^16.
- R7: JSR (code 7) copies the PC to the link register and loads the PC with {A,B}, without the +2 step.
- R8: RET (code 8) sets the PC to the link register plus 2.
- R9: STOREJUMP (code 11) loads the link register with {A,B}, and the PC steps by 2.
- R10: With `commit` low, LOADJUMP0 (code 9) drives the link register's low byte on `c_bus_out` and LOADJUMP1 (code 10) drives its high byte, both with `c_drive_en` high. At every other time `c_drive_en` is low and `c_bus_out` is zero. Both operations step the PC by 2 on commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit | input | 1 | 1 = Commit phase, 0 = Execute phase |
| op | input | 4 | Decoded PC operation code |
| a_bus | input | 8 | A-bus byte (address high byte or displacement) |
| b_bus | input | 8 | B-bus byte (address low byte or branch zero test) |
| c_val | input | 8 | Register C value for the JUMPZERO test |
| c_bus_out | output | 8 | Link register byte returned to the C bus |
| c_drive_en | output | 1 | High while `c_bus_out` carries a link register byte |
| pc_q | output | 16 | Current program counter |

## Verification
The C-bus byte and its enable are combinational. They are due in the same Execute cycle the operation is presented, and the bench samples them a few nanoseconds after driving the inputs at a falling edge. PC and link register changes land on the rising edge that ends the Commit cycle. The bench therefore samples `pc_q` at the falling edge after that one, and also at the falling edge that ends the Execute cycle, where the PC must not have moved yet. The link register is observed only through LOADJUMP readouts, so the random mix includes those operations regularly.

// File: rtl/pc_pkg.sv
package pc_pkg;

    localparam int ADDR_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int INSN_BYTES = 2;
    localparam int OP_W       = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [OP_W-1:0] {
        PCOP_STEP       = 4'd0,
        PCOP_JUMP       = 4'd1,
        PCOP_JUMPZ      = 4'd2,
        PCOP_BR_FWD     = 4'd3,
        PCOP_BR_FWD_Z   = 4'd4,
        PCOP_BR_BACK    = 4'd5,
        PCOP_BR_BACK_Z  = 4'd6,
        PCOP_CALL       = 4'd7,
        PCOP_RETURN     = 4'd8,
        PCOP_LINK_RD_LO = 4'd9,
        PCOP_LINK_RD_HI = 4'd10,
        PCOP_LINK_WR    = 4'd11
    } pc_op_e;

    // Result of one commit: next PC and next link register
    typedef struct packed {
        addr_t pc;
        addr_t link;
    } pc_state_t;

    function automatic addr_t join_bytes(input byte_t hi, input byte_t lo);
        return {hi, lo};
    endfunction

    function automatic addr_t zext(input byte_t v);
        return addr_t'(v);
    endfunction

    function automatic addr_t step_of(input addr_t base);
        return base + addr_t'(INSN_BYTES);
    endfunction

endpackage

// File: rtl/pc_next_calc.sv
module pc_next_calc
    import pc_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  addr_t           pc_cur,
    input  addr_t           link_cur,
    input  byte_t           a_bus,
    input  byte_t           b_bus,
    input  byte_t           c_val,
    output pc_state_t       nxt
);

    addr_t seq_pc;
    addr_t abs_tgt;
    addr_t fwd_tgt;
    addr_t back_tgt;
    logic  b_zero;
    logic  c_zero;

    always_comb begin
        seq_pc   = step_of(pc_cur);
        abs_tgt  = join_bytes(a_bus, b_bus);
        fwd_tgt  = pc_cur + zext(a_bus);
        // backward branch keeps the sequential step after subtracting
        back_tgt = step_of(pc_cur - zext(a_bus));
        b_zero   = (b_bus == '0);
        c_zero   = (c_val == '0);
    end

    always_comb begin
        nxt.pc   = seq_pc;
        nxt.link = link_cur;
        case (op)
            PCOP_JUMP:      nxt.pc = abs_tgt;
            PCOP_JUMPZ:     nxt.pc = c_zero ? abs_tgt : seq_pc;
            PCOP_BR_FWD:    nxt.pc = fwd_tgt;
            PCOP_BR_FWD_Z:  nxt.pc = b_zero ? fwd_tgt : seq_pc;
            PCOP_BR_BACK:   nxt.pc = back_tgt;
            PCOP_BR_BACK_Z: nxt.pc = b_zero ? back_tgt : seq_pc;
            PCOP_CALL: begin
                nxt.pc   = abs_tgt;
                nxt.link = pc_cur;
            end
            PCOP_RETURN:    nxt.pc = step_of(link_cur);
            PCOP_LINK_WR:   nxt.link = abs_tgt;
            default:        nxt.pc = seq_pc;
        endcase
    end

endmodule

// File: rtl/pc_cbus_drv.sv
module pc_cbus_drv
    import pc_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            commit,
    input  addr_t           link_cur,
    output byte_t           c_bus_out,
    output logic            c_drive_en
);

    logic sel_lo;
    logic sel_hi;

    always_comb begin
        sel_lo     = !commit && (op == PCOP_LINK_RD_LO);
        sel_hi     = !commit && (op == PCOP_LINK_RD_HI);
        c_drive_en = sel_lo || sel_hi;
        c_bus_out  = '0;
        if (sel_lo) c_bus_out = link_cur[BYTE_W-1:0];
        if (sel_hi) c_bus_out = link_cur[ADDR_W-1 -: BYTE_W];
    end

endmodule

// File: rtl/pc_unit.sv
module pc_unit
    import pc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        commit,
    input  logic [3:0]  op,
    input  logic [7:0]  a_bus,
    input  logic [7:0]  b_bus,
    input  logic [7:0]  c_val,
    output logic [7:0]  c_bus_out,
    output logic        c_drive_en,
    output logic [15:0] pc_q
);

    addr_t     pc_r;
    addr_t     link_r;
    pc_state_t nxt;

    pc_next_calc u_next (
        .op       (op),
        .pc_cur   (pc_r),
        .link_cur (link_r),
        .a_bus    (a_bus),
        .b_bus    (b_bus),
        .c_val    (c_val),
        .nxt      (nxt)
    );

    pc_cbus_drv u_cbus (
        .op         (op),
        .commit     (commit),
        .link_cur   (link_r),
        .c_bus_out  (c_bus_out),
        .c_drive_en (c_drive_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_r   <= '0;
            link_r <= '0;
        end else if (commit) begin
            pc_r   <= nxt.pc;
            link_r <= nxt.link;
        end
    end

    assign pc_q = pc_r;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (pc_r == '0) && (link_r == '0));

    assert_exec_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(pc_r) && $stable(link_r));

    assert_plain_step_R3: assert property (@(posedge clk) disable iff (rst)
        commit && op == PCOP_STEP |=> pc_r == $past(pc_r) + 16'd2);

    assert_fwd_zero_halt_R5: assert property (@(posedge clk) disable iff (rst)
        commit && op == PCOP_BR_FWD && a_bus == 8'd0 |=> $stable(pc_r));

    assert_back_two_halt_R6: assert property (@(posedge clk) disable iff (rst)
        commit && op == PCOP_BR_BACK && a_bus == 8'd2 |=> $stable(pc_r));

    assert_call_links_R7: assert property (@(posedge clk) disable iff (rst)
        commit && op == PCOP_CALL |=> link_r == $past(pc_r));

    assert_cbus_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !c_drive_en |-> c_bus_out == 8'd0);

    assert_cbus_no_commit_R10: assert property (@(posedge clk) disable iff (rst)
        commit |-> !c_drive_en);

endmodule

// File: tb/pc_unit_tb.sv
module pc_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        commit = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [7:0]  a_bus = 8'd0;
    logic [7:0]  b_bus = 8'd0;
    logic [7:0]  c_val = 8'd0;
    logic [7:0]  c_bus_out;
    logic        c_drive_en;
    logic [15:0] pc_q;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_pc = 16'd0;
    logic [15:0] m_link = 16'd0;
    bit done = 1'b0;

    pc_unit u_dut (
        .clk(clk), .rst(rst), .commit(commit), .op(op),
        .a_bus(a_bus), .b_bus(b_bus), .c_val(c_val),
        .c_bus_out(c_bus_out), .c_drive_en(c_drive_en), .pc_q(pc_q)
    );

    always #10 clk = ~clk;

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd1, 4'd2: return "R4";
            4'd3, 4'd4: return "R5";
            4'd5, 4'd6: return "R6";
            4'd7:       return "R7";
            4'd8:       return "R8";
            4'd9, 4'd10: return "R10";
            4'd11:      return "R9";
            default:    return "R3";
        endcase
    endfunction

    function automatic logic [15:0] exp_pc(input logic [3:0] o, input logic [15:0] pc,
            input logic [15:0] lk, input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        logic [15:0] stp;
        stp = pc + 16'd2;
        case (o)
            4'd1: return {a, b};
            4'd2: return (c == 0) ? {a, b} : stp;
            4'd3: return pc + {8'd0, a};
            4'd4: return (b == 0) ? pc + {8'd0, a} : stp;
            4'd5: return pc - {8'd0, a} + 16'd2;
            4'd6: return (b == 0) ? pc - {8'd0, a} + 16'd2 : stp;
            4'd7: return {a, b};
            4'd8: return lk + 16'd2;
            default: return stp;
        endcase
    endfunction

    function automatic logic [15:0] exp_link(input logic [3:0] o, input logic [15:0] pc,
            input logic [15:0] lk, input logic [7:0] a, input logic [7:0] b);
        if (o == 4'd7)  return pc;
        if (o == 4'd11) return {a, b};
        return lk;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one instruction: Execute cycle then Commit cycle
    task automatic run_op(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
            input logic [7:0] c);
        logic [7:0] exp_c;
        logic exp_en;
        @(negedge clk);
        op = o; a_bus = a; b_bus = b; c_val = c; commit = 1'b0;
        #2;
        exp_en = (o == 4'd9) || (o == 4'd10);
        exp_c  = (o == 4'd9) ? m_link[7:0] : (o == 4'd10) ? m_link[15:8] : 8'd0;
        check("R10", {31'd0, c_drive_en}, {31'd0, exp_en});
        check("R10", {24'd0, c_bus_out}, {24'd0, exp_c});
        @(negedge clk);
        check("R2", {16'd0, pc_q}, {16'd0, m_pc});
        commit = 1'b1;
        #2;
        check("R10", {31'd0, c_drive_en}, 32'd0);
        @(negedge clk);
        commit = 1'b0; op = 4'd0;
        m_link = exp_link(o, m_pc, m_link, a, b);
        m_pc   = exp_pc(o, m_pc, m_link, a, b, c);
        check(req_of(o), {16'd0, pc_q}, {16'd0, m_pc});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        logic [3:0] o;
        logic [7:0] a, b, c;
        seed = 32'd20240611;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1", {16'd0, pc_q}, 32'd0);
        // R1: link cleared, read back low and high bytes
        run_op(4'd9, 8'h00, 8'h00, 8'h00);
        run_op(4'd10, 8'h00, 8'h00, 8'h00);
        // R3 wrap and unassigned code
        run_op(4'd1, 8'hFF, 8'hFE, 8'h00);
        run_op(4'd0, 8'h00, 8'h00, 8'h00);
        run_op(4'd15, 8'h00, 8'h00, 8'h00);
        // R4 conditional taken and not taken
        run_op(4'd2, 8'h12, 8'h34, 8'h00);
        run_op(4'd2, 8'h56, 8'h78, 8'h01);
        // R5 halt with zero displacement, conditional variants
        run_op(4'd3, 8'h00, 8'h00, 8'h00);
        run_op(4'd4, 8'h10, 8'h00, 8'h00);
        run_op(4'd4, 8'h10, 8'h05, 8'h00);
        // R6 halt with displacement 2, wrap below zero
        run_op(4'd5, 8'h02, 8'h00, 8'h00);
        run_op(4'd1, 8'h00, 8'h04, 8'h00);
        run_op(4'd5, 8'h80, 8'h00, 8'h00);
        run_op(4'd6, 8'h08, 8'h01, 8'h00);
        // R7 / R8 call and return, R10 readout of link
        run_op(4'd7, 8'hAB, 8'hCD, 8'h00);
        run_op(4'd9, 8'h00, 8'h00, 8'h00);
        run_op(4'd10, 8'h00, 8'h00, 8'h00);
        run_op(4'd8, 8'h00, 8'h00, 8'h00);
        // R9 store link then return
        run_op(4'd11, 8'h9A, 8'hBC, 8'h00);
        run_op(4'd10, 8'h00, 8'h00, 8'h00);
        run_op(4'd8, 8'h00, 8'h00, 8'h00);
        // random mix
        for (int i = 0; i < 400; i++) begin
            o = 4'($urandom_range(0, 15));
            a = 8'($urandom);
            b = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom);
            c = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom);
            run_op(o, a, b, c);
        end
        // R1 mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_pc = 16'd0; m_link = 16'd0;
        check("R1", {16'd0, pc_q}, 32'd0);
        run_op(4'd10, 8'h00, 8'h00, 8'h00);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule